// File: doc/BRIEF.md
# DMA Descriptor Status Tracker

This block follows one DMA descriptor from the moment its transfer is launched until both ends of the transfer have finished. It keeps two residual word counters, one for the source side and one for the destination side. Both are loaded with the programmed word count at launch, and each is decremented by the beat pulses of its own engine. Success or failure is judged separately at each end: a zero residue means that end finished cleanly, and a residue left behind by an error pulse shows where the transfer broke off.

Four flags summarise the outcome in a status word: in progress, finished cleanly, source fault and destination fault. The finished and fault flags drive an interrupt line. One write-one-to-clear strobe wipes all three of them together. The status word and a packed word holding both residues can be read through a one-bit-address read port. They are also available directly as outputs.

Top module: `dma_desc_tracker`

## Requirements
- R1: After reset, the status word, the residue word and the interrupt line are all zero.
- R2: In the status word, bit 0 is in-progress, bit 1 is finished-cleanly, bit 2 is source fault and bit 3 is destination fault; all higher bits read zero. The residue word holds the source residue in bits 15:0 and the destination residue in bits 31:16. The read port returns the status word when the select is 0 and the residue word when it is 1. With the default configuration, it does so in the same cycle.
- R3: A launch with a nonzero count while the block is idle takes effect at the next clock edge. In-progress becomes 1, both residues equal the count, and all three outcome flags are cleared. A launch with a count of zero is ignored.
- R4: While in progress, a beat pulse lowers its own end's residue by exactly one, unless that end is already at zero or has faulted. Beats while idle change nothing.
- R5: While in progress, an error pulse at an end whose residue is nonzero and which has not faulted sets that end's fault flag and freezes the residue. A beat in the same cycle is dropped. Error pulses at a finished end, or while idle, are ignored.
- R6: In-progress drops at the same edge at which both ends have reached zero or faulted, and not before.
- R7: Finished-cleanly sets at the edge where in-progress drops, and only if neither end faulted during the transfer.
- R8: The interrupt line is the OR of the finished-cleanly and both fault flags. The clear strobe zeroes all three at the next edge.
- R9: When a flag-setting event and the clear strobe come in the same cycle, the flag ends up set.
- R10: A launch while in progress is ignored; the residues continue from their current values.
- R11: Clearing a fault flag during a transfer does not resume counting at that end. Its residue stays frozen until the next launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch request from descriptor control |
| start_count_i | input | 16 | Programmed word count for the launch |
| src_beat_i | input | 1 | One source word moved |
| dst_beat_i | input | 1 | One destination word moved |
| src_err_i | input | 1 | Source-side error pulse |
| dst_err_i | input | 1 | Destination-side error pulse |
| irq_clr_i | input | 1 | Write-one-to-clear strobe for outcome flags |
| rd_sel_i | input | 1 | Read select: 0 status, 1 residues |
| rd_data_o | output | 32 | Read data |
| status_o | output | 32 | Status word |
| pending_o | output | 32 | Packed residue word |
| irq_o | output | 1 | Interrupt line |

## Verification
Several rules are checked by assertions on every cycle. A residue never moves by more than one per cycle, and a faulted end stays frozen. A fault flag only rises during a transfer. In-progress never drops while an end is still live. Finished-cleanly never rises with a nonzero residue. The interrupt only falls after a clear or a launch, and a busy-time launch never reloads the counters. Other behaviours only show up in the bench's scenarios: the exact residue values, a fault whose flag was cleared leaving no clean finish, a set event winning over a simultaneous clear, a zero-count launch, and the read-select mapping. For these, a behavioural reference model is compared with the outputs every cycle.

// File: rtl/dma_trk_pkg.sv
package dma_trk_pkg;

   localparam int unsigned NUM_ENDS = 2;
   localparam int unsigned END_SRC  = 0;
   localparam int unsigned END_DST  = 1;

   localparam int unsigned ST_ACTIVE = 0;
   localparam int unsigned ST_DONE   = 1;
   localparam int unsigned ST_SFAULT = 2;
   localparam int unsigned ST_DFAULT = 3;

   typedef enum logic {
      SEL_STATUS  = 1'b0,
      SEL_PENDING = 1'b1
   } rd_sel_e;

endpackage

// File: rtl/dma_trk_residual.sv
module dma_trk_residual #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             active_i,
   input  logic             beat_i,
   input  logic             err_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             halt_o,
   output logic             flag_o,
   output logic             done_nxt_o,
   output logic             clean_nxt_o
);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             halt_q, halt_d;
   logic             flag_q, flag_d;
   logic             live, err_hit, step;

   assign live    = active_i && (cnt_q != '0) && !halt_q;
   assign err_hit = live && err_i;
   assign step    = live && !err_i && beat_i;

   always_comb begin
      cnt_d  = cnt_q;
      halt_d = halt_q;
      flag_d = flag_q;
      if (load_i) begin
         cnt_d  = load_val_i;
         halt_d = 1'b0;
         flag_d = 1'b0;
      end else begin
         if (step) cnt_d = cnt_q - 1'b1;
         halt_d = halt_q | err_hit;
         flag_d = err_hit | (flag_q & ~clr_i);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         halt_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         halt_q <= halt_d;
         flag_q <= flag_d;
      end
   end

   assign cnt_o       = cnt_q;
   assign halt_o      = halt_q;
   assign flag_o      = flag_q;
   assign done_nxt_o  = (cnt_d == '0) || halt_d;
   assign clean_nxt_o = !halt_d;

   assert_unit_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - 1'b1));

   assert_frozen_after_fault_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (halt_q && !load_i) |=> (cnt_q == $past(cnt_q)) && halt_q);

   assert_fault_needs_active_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_q) |-> $past(active_i));

endmodule

// File: rtl/dma_trk_ctrl.sv
module dma_trk_ctrl
   import dma_trk_pkg::*;
(
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                start_ok_i,
   input  logic                clr_i,
   input  logic [NUM_ENDS-1:0] done_nxt_i,
   input  logic [NUM_ENDS-1:0] clean_nxt_i,
   output logic                active_o,
   output logic                complete_o
);

   logic active_q, active_d;
   logic complete_q, complete_d;
   logic finish, cmp_set;

   assign finish  = active_q && (&done_nxt_i);
   assign cmp_set = finish && (&clean_nxt_i);

   always_comb begin
      if (start_ok_i) begin
         active_d   = 1'b1;
         complete_d = 1'b0;
      end else begin
         active_d   = finish ? 1'b0 : active_q;
         complete_d = cmp_set | (complete_q & ~clr_i);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         active_q   <= 1'b0;
         complete_q <= 1'b0;
      end else begin
         active_q   <= active_d;
         complete_q <= complete_d;
      end
   end

   assign active_o   = active_q;
   assign complete_o = complete_q;

   assert_hold_while_live_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_q && !(&done_nxt_i)) |=> active_q);

   assert_set_beats_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_set && clr_i) |=> complete_q);

endmodule

// File: rtl/dma_trk_rdport.sv
module dma_trk_rdport
   import dma_trk_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter bit          RD_REG = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sel_i,
   input  logic [DATA_W-1:0] status_i,
   input  logic [DATA_W-1:0] pending_i,
   output logic [DATA_W-1:0] data_o
);

   rd_sel_e           sel;
   logic [DATA_W-1:0] mux;

   assign sel = rd_sel_e'(sel_i);
   assign mux = (sel == SEL_PENDING) ? pending_i : status_i;

   if (RD_REG) begin : g_reg
      logic [DATA_W-1:0] data_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) data_q <= '0;
         else         data_q <= mux;
      end
      assign data_o = data_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign data_o = mux;
   end

endmodule

// File: rtl/dma_desc_tracker.sv
module dma_desc_tracker
   import dma_trk_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 32,
   parameter bit          RD_REG = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  start_count_i,
   input  logic              src_beat_i,
   input  logic              dst_beat_i,
   input  logic              src_err_i,
   input  logic              dst_err_i,
   input  logic              irq_clr_i,
   input  logic              rd_sel_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [DATA_W-1:0] status_o,
   output logic [DATA_W-1:0] pending_o,
   output logic              irq_o
);

   localparam int unsigned PEND_W = NUM_ENDS * CNT_W;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("dma_desc_tracker: CNT_W must be at least 2");
   end
   if (DATA_W < PEND_W || DATA_W <= ST_DFAULT) begin : g_bad_data
      $error("dma_desc_tracker: DATA_W too narrow for packed residues");
   end

   logic [NUM_ENDS-1:0] beat_v, err_v;
   logic [NUM_ENDS-1:0] halt_v, flag_v, done_nxt_v, clean_nxt_v;
   logic [CNT_W-1:0]    cnt_v [NUM_ENDS];
   logic                active, complete, start_ok;

   assign beat_v[END_SRC] = src_beat_i;
   assign beat_v[END_DST] = dst_beat_i;
   assign err_v[END_SRC]  = src_err_i;
   assign err_v[END_DST]  = dst_err_i;

   assign start_ok = start_i && !active && (start_count_i != '0);

   for (genvar e = 0; e < NUM_ENDS; e++) begin : g_end
      dma_trk_residual #(.CNT_W(CNT_W)) u_res (
         .clk_i       (clk_i),
         .rst_ni      (rst_ni),
         .load_i      (start_ok),
         .load_val_i  (start_count_i),
         .active_i    (active),
         .beat_i      (beat_v[e]),
         .err_i       (err_v[e]),
         .clr_i       (irq_clr_i),
         .cnt_o       (cnt_v[e]),
         .halt_o      (halt_v[e]),
         .flag_o      (flag_v[e]),
         .done_nxt_o  (done_nxt_v[e]),
         .clean_nxt_o (clean_nxt_v[e])
      );
   end

   dma_trk_ctrl u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_ok_i  (start_ok),
      .clr_i       (irq_clr_i),
      .done_nxt_i  (done_nxt_v),
      .clean_nxt_i (clean_nxt_v),
      .active_o    (active),
      .complete_o  (complete)
   );

   always_comb begin
      status_o            = '0;
      status_o[ST_ACTIVE] = active;
      status_o[ST_DONE]   = complete;
      status_o[ST_SFAULT] = flag_v[END_SRC];
      status_o[ST_DFAULT] = flag_v[END_DST];
   end

   always_comb begin
      pending_o = '0;
      for (int e = 0; e < NUM_ENDS; e++) begin
         pending_o[e*CNT_W +: CNT_W] = cnt_v[e];
      end
   end

   assign irq_o = complete | flag_v[END_SRC] | flag_v[END_DST];

   dma_trk_rdport #(.DATA_W(DATA_W), .RD_REG(RD_REG)) u_rd (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sel_i     (rd_sel_i),
      .status_i  (status_o),
      .pending_i (pending_o),
      .data_o    (rd_data_o)
   );

   assert_clean_finish_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(complete) |-> !active && (cnt_v[END_SRC] == '0) && (cnt_v[END_DST] == '0)
                          && !halt_v[END_SRC] && !halt_v[END_DST]);

   assert_stop_when_ends_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(active) |-> ((cnt_v[END_SRC] == '0) || halt_v[END_SRC])
                        && ((cnt_v[END_DST] == '0) || halt_v[END_DST]));

   assert_irq_fall_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_o) |-> $past(irq_clr_i) || $past(start_ok));

   assert_busy_launch_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active && start_i) |=> (cnt_v[END_SRC] <= $past(cnt_v[END_SRC]))
                              && (cnt_v[END_DST] <= $past(cnt_v[END_DST])));

endmodule

// File: tb/dma_desc_tracker_tb_top.sv
module dma_desc_tracker_tb_top;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] count = '0;
   logic        sbeat = 1'b0, dbeat = 1'b0, serr = 1'b0, derr = 1'b0, clr = 1'b0;
   logic        rd_sel = 1'b0;
   logic [31:0] rd_data, status, pending;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   dma_desc_tracker #(.CNT_W(16), .DATA_W(32), .RD_REG(1'b0)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_count_i(count),
      .src_beat_i(sbeat), .dst_beat_i(dbeat), .src_err_i(serr), .dst_err_i(derr),
      .irq_clr_i(clr), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
      .status_o(status), .pending_o(pending), .irq_o(irq)
   );

   // Behavioural reference model
   int  m_sc = 0, m_dc = 0;
   bit  m_act = 0, m_cmp = 0, m_se = 0, m_de = 0, m_sh = 0, m_dh = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sc = 0; m_dc = 0; m_act = 0; m_cmp = 0;
         m_se = 0; m_de = 0; m_sh = 0; m_dh = 0;
      end else if (start && !m_act && count != 0) begin
         m_sc = count; m_dc = count; m_act = 1; m_cmp = 0;
         m_se = 0; m_de = 0; m_sh = 0; m_dh = 0;
      end else begin
         bit se_set, de_set, c_set;
         se_set = 0; de_set = 0; c_set = 0;
         if (m_act && m_sc > 0 && !m_sh) begin
            if (serr) begin m_sh = 1; se_set = 1; end
            else if (sbeat) m_sc = m_sc - 1;
         end
         if (m_act && m_dc > 0 && !m_dh) begin
            if (derr) begin m_dh = 1; de_set = 1; end
            else if (dbeat) m_dc = m_dc - 1;
         end
         m_se = se_set ? 1'b1 : (clr ? 1'b0 : m_se);
         m_de = de_set ? 1'b1 : (clr ? 1'b0 : m_de);
         if (m_act && (m_sc == 0 || m_sh) && (m_dc == 0 || m_dh)) begin
            m_act = 0;
            if (!m_sh && !m_dh) c_set = 1;
         end
         m_cmp = c_set ? 1'b1 : (clr ? 1'b0 : m_cmp);
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         logic [31:0] e_st, e_pd;
         e_st = {28'd0, m_de, m_se, m_cmp, m_act};
         e_pd = {m_dc[15:0], m_sc[15:0]};
         chk("R2/R5/R6/R7 status word", status, e_st);
         chk("R4 residue word", pending, e_pd);
         chk("R8 irq line", {31'd0, irq}, {31'd0, m_cmp | m_se | m_de});
         chk("R2 read port", rd_data, rd_sel ? e_pd : e_st);
      end
   end

   task automatic cyc();
      @(negedge clk);
      #1;
      rd_sel = ~rd_sel;
   endtask

   task automatic quiet();
      start = 0; sbeat = 0; dbeat = 0; serr = 0; derr = 0; clr = 0;
   endtask

   initial begin
      #(CLK_P * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) cyc();
      rst_n = 1;
      cyc();
      chk("R1 reset status", status, 32'h0);
      chk("R1 reset residues", pending, 32'h0);
      chk("R1 reset irq", {31'd0, irq}, 32'h0);

      // clean transfer of 3 words
      start = 1; count = 16'd3; cyc(); quiet();
      chk("R3 launch status", status, 32'h1);
      chk("R3 launch residues", pending, 32'h0003_0003);
      sbeat = 1; dbeat = 1; cyc(); cyc();
      dbeat = 0; cyc();
      chk("R6 still active with dst live", status, 32'h1);
      chk("R4 residues after src done", pending, 32'h0001_0000);
      sbeat = 0; dbeat = 1; cyc(); quiet();
      chk("R7 clean finish", status, 32'h2);
      chk("R8 irq on finish", {31'd0, irq}, 32'h1);
      sbeat = 1; dbeat = 1; cyc(); quiet();
      chk("R4 idle beats ignored", pending, 32'h0);
      clr = 1; cyc(); quiet();
      chk("R8 clear wipes flags", status, 32'h0);
      chk("R8 irq low after clear", {31'd0, irq}, 32'h0);

      // zero-count launch
      start = 1; count = 16'd0; cyc(); quiet();
      chk("R3 zero count ignored", status, 32'h0);

      // source fault
      start = 1; count = 16'd5; cyc(); quiet();
      sbeat = 1; cyc(); cyc();
      serr = 1; cyc(); quiet();
      chk("R5 source fault flag", status, 32'h5);
      chk("R5 residue frozen", pending, 32'h0005_0003);
      clr = 1; cyc(); quiet();
      chk("R11 fault flag cleared, active", status, 32'h1);
      sbeat = 1; cyc(); cyc(); quiet();
      chk("R11 no resume after clear", pending, 32'h0005_0003);
      dbeat = 1; repeat (5) cyc(); quiet();
      chk("R7 no clean finish after fault", status, 32'h0);
      chk("R7 source residue kept", pending, 32'h0000_0003);
      derr = 1; cyc(); quiet();
      chk("R5 idle error ignored", status, 32'h0);

      // set wins over clear
      start = 1; count = 16'd1; cyc(); quiet();
      sbeat = 1; cyc(); quiet();
      derr = 1; clr = 1; cyc(); quiet();
      chk("R9 fault beats clear", status, 32'h8);
      chk("R9 residues", pending, 32'h0001_0000);
      start = 1; count = 16'd1; cyc(); quiet();
      chk("R3 relaunch clears flags", status, 32'h1);
      sbeat = 1; dbeat = 1; clr = 1; cyc(); quiet();
      chk("R9 finish beats clear", status, 32'h2);

      // launch while busy
      start = 1; count = 16'd4; cyc(); quiet();
      sbeat = 1; dbeat = 1; cyc(); quiet();
      start = 1; count = 16'd9; sbeat = 1; cyc(); quiet();
      chk("R10 busy launch ignored", pending, 32'h0003_0002);
      chk("R10 status unchanged", status, 32'h1);
      cyc();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule